// File: doc/BRIEF.md
# Eye-Opening Lock Monitor

This block checks link quality once the clock-and-data-recovery loop reports lock and equalizer adaptation has finished. While the monitor is enabled and both conditions hold, an interval timer counts a programmable number of base intervals. Each base interval is `TICKS_PER_BASE` pulses of a slow clock-enable tick; for example, 13 ticks of 0.5 ms give 6.5 ms. When the timer expires, the block asks an external eye-measurement engine for a horizontal and a vertical opening. It does this with a one-cycle start pulse and then waits for a done pulse.

Each returned measurement carries several values: the horizontal opening (0 to 63 phase steps), the vertical opening (0 to 63 voltage steps), a flag saying no zero-crossing errors were seen, and a flag saying the eye is fully closed. The block compares the openings with two pairs of 4-bit thresholds, each scaled by four. The lock pair decides the qualified-lock output. The alarm pair raises a one-cycle eye event when the eye has degraded. A manual request can start a measurement at once, but only when a manual-override enable is set. A missing done within a timeout counts as a failed check.

Top module: `eye_lock_monitor`

## Requirements
- R1: During and directly after reset, `meas_start_o`, `lock_ok_o`, `eye_evt_o` and `clean_o` are all 0.
- R2: No measurement starts unless `mon_en_i`, `cdr_lock_i` and `adapt_done_i` are all 1.
- R3: The first start pulse comes P×`TICKS_PER_BASE` tick-enabled cycles after monitoring becomes active. P is `period_i`, and a value of 0 is treated as 1. The timer restarts from zero after every measurement and whenever activity is lost.
- R4: `meas_start_o` is a single-cycle pulse. No further start is issued until the current request ends by a done or a timeout.
- R5: On an accepted done, `lock_ok_o` becomes 1 in the next cycle when HEO ≥ 4×`heo_lock_thr_i` and VEO ≥ 4×`veo_lock_thr_i`. Otherwise it becomes 0.
- R6: A measurement with `meas_closed_i`=1 fails both comparisons, whatever the HEO and VEO values are.
- R7: `eye_evt_o` pulses for one cycle, in the cycle after an accepted done, when HEO < 4×`heo_irq_thr_i`, or VEO < 4×`veo_irq_thr_i`, or the eye is closed.
- R8: `man_req_i` starts a measurement immediately only while `man_ovr_en_i`=1, monitoring is active and no request is pending. In every other case it is ignored.
- R9: If no done arrives within `TIMEOUT_CYC` cycles of the start pulse, the request is abandoned. `lock_ok_o` clears on the next edge, no eye event is raised, and the timer restarts.
- R10: `lock_ok_o` falls in the same cycle that `cdr_lock_i` falls. It stays 0 after lock returns until a later measurement passes.
- R11: A done pulse that arrives while no request is pending is ignored.
- R12: `clean_o` holds the no-zero-crossing-error flag of the most recently accepted measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Slow clock-enable tick for the interval timer |
| mon_en_i | input | 1 | Monitor enable |
| cdr_lock_i | input | 1 | Raw recovery-loop lock |
| adapt_done_i | input | 1 | Equalizer adaptation finished |
| period_i | input | 4 | Base intervals per check (0 treated as 1) |
| heo_lock_thr_i | input | 4 | Horizontal lock threshold, ×4 |
| veo_lock_thr_i | input | 4 | Vertical lock threshold, ×4 |
| heo_irq_thr_i | input | 4 | Horizontal alarm threshold, ×4 |
| veo_irq_thr_i | input | 4 | Vertical alarm threshold, ×4 |
| man_ovr_en_i | input | 1 | Enables manual measurement requests |
| man_req_i | input | 1 | Manual request pulse |
| meas_start_o | output | 1 | One-cycle measurement start |
| meas_done_i | input | 1 | Measurement done pulse |
| meas_heo_i | input | 6 | Measured horizontal opening |
| meas_veo_i | input | 6 | Measured vertical opening |
| meas_no_hits_i | input | 1 | No zero-crossing errors seen |
| meas_closed_i | input | 1 | Eye fully closed |
| lock_ok_o | output | 1 | Qualified lock |
| eye_evt_o | output | 1 | One-cycle eye alarm event |
| clean_o | output | 1 | Latched no-error flag of last measurement |

## Verification
The cycle-by-cycle properties cover the following:
- the start pulse is a single cycle wide;
- a start follows only from cycles in which monitoring was fully enabled;
- an event or a rising qualified lock always traces back to a done accepted during a pending request;
- a closed eye never yields lock.

Other behaviours can only be shown by bench scenarios. These are the exact interval lengths for several period values, including zero, and the timeout edge counted to the cycle. They also include the threshold boundaries at exactly four times the nibble, manual requests being dropped without the override, stray done pulses while idle, and lock staying low after the recovery loop re-locks.

// File: rtl/eye_mon_pkg.sv
package eye_mon_pkg;

    localparam int EYE_W = 6;
    localparam int THR_W = 4;
    localparam int PER_W = 4;

    typedef enum logic {
        ACQ_IDLE = 1'b0,
        ACQ_WAIT = 1'b1
    } acq_state_e;

    typedef struct packed {
        logic [EYE_W-1:0] heo;
        logic [EYE_W-1:0] veo;
        logic             no_hits;
        logic             closed;
    } eye_meas_t;

    typedef struct packed {
        logic [THR_W-1:0] heo;
        logic [THR_W-1:0] veo;
    } eye_thr_t;

    // value compared against nibble scaled by four
    function automatic logic meets_thr(input logic [EYE_W-1:0] val,
                                       input logic [THR_W-1:0] thr);
        return val >= {thr, 2'b00};
    endfunction

    // closed eye fails regardless of reported openings
    function automatic logic eye_pass(input eye_meas_t m, input eye_thr_t t);
        return !m.closed && meets_thr(m.heo, t.heo) && meets_thr(m.veo, t.veo);
    endfunction

endpackage

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int TICKS_PER_BASE = 13,
    parameter int PER_W          = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [PER_W-1:0] period_i,
    output logic             expire_o
);
    localparam int TW = (TICKS_PER_BASE > 1) ? $clog2(TICKS_PER_BASE) : 1;

    logic [TW-1:0]    tick_cnt;
    logic [PER_W-1:0] base_cnt;
    logic [PER_W-1:0] limit_m1;
    logic             tick_last;
    logic             base_last;

    always_comb begin
        limit_m1  = (period_i == '0) ? '0 : period_i - 1'b1;
        tick_last = (tick_cnt == TW'(TICKS_PER_BASE - 1));
        base_last = (base_cnt == limit_m1);
        expire_o  = run_i && tick_i && tick_last && base_last;
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            tick_cnt <= '0;
            base_cnt <= '0;
        end else if (tick_i) begin
            if (tick_last) begin
                tick_cnt <= '0;
                base_cnt <= base_last ? '0 : base_cnt + 1'b1;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import eye_mon_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic trig_i,
    input  logic done_i,
    output logic start_o,
    output logic waiting_o,
    output logic accept_o,
    output logic timeout_o
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);

    acq_state_e    state;
    logic [CW-1:0] to_cnt;
    logic          start_q;

    always_comb begin
        waiting_o = (state == ACQ_WAIT);
        accept_o  = waiting_o && active_i && done_i;
        timeout_o = waiting_o && active_i && !done_i
                    && (to_cnt == CW'(TIMEOUT_CYC - 1));
        start_o   = start_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ACQ_IDLE;
            to_cnt  <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            unique case (state)
                ACQ_IDLE: begin
                    to_cnt <= '0;
                    if (active_i && trig_i) begin
                        state   <= ACQ_WAIT;
                        start_q <= 1'b1;
                    end
                end
                ACQ_WAIT: begin
                    if (!active_i || accept_o || timeout_o) begin
                        state  <= ACQ_IDLE;
                        to_cnt <= '0;
                    end else begin
                        to_cnt <= to_cnt + 1'b1;
                    end
                end
                default: state <= ACQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/eye_qualifier.sv
module eye_qualifier
    import eye_mon_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cdr_lock_i,
    input  logic      accept_i,
    input  logic      timeout_i,
    input  eye_meas_t meas_i,
    input  eye_thr_t  lock_thr_i,
    input  eye_thr_t  irq_thr_i,
    output logic      lock_ok_o,
    output logic      evt_o,
    output logic      clean_o
);
    logic lock_q;
    logic evt_q;
    logic clean_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q  <= 1'b0;
            evt_q   <= 1'b0;
            clean_q <= 1'b0;
        end else begin
            evt_q <= accept_i && !eye_pass(meas_i, irq_thr_i);
            if (accept_i) begin
                clean_q <= meas_i.no_hits;
            end
            if (!cdr_lock_i || timeout_i) begin
                lock_q <= 1'b0;
            end else if (accept_i) begin
                lock_q <= eye_pass(meas_i, lock_thr_i);
            end
        end
    end

    // raw lock loss removes qualified lock without waiting for an edge
    assign lock_ok_o = lock_q && cdr_lock_i;
    assign evt_o     = evt_q;
    assign clean_o   = clean_q;

endmodule

// File: rtl/eye_lock_monitor.sv
module eye_lock_monitor
    import eye_mon_pkg::*;
#(
    parameter int TICKS_PER_BASE = 13,
    parameter int TIMEOUT_CYC    = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             mon_en_i,
    input  logic             cdr_lock_i,
    input  logic             adapt_done_i,
    input  logic [PER_W-1:0] period_i,
    input  logic [THR_W-1:0] heo_lock_thr_i,
    input  logic [THR_W-1:0] veo_lock_thr_i,
    input  logic [THR_W-1:0] heo_irq_thr_i,
    input  logic [THR_W-1:0] veo_irq_thr_i,
    input  logic             man_ovr_en_i,
    input  logic             man_req_i,
    output logic             meas_start_o,
    input  logic             meas_done_i,
    input  logic [EYE_W-1:0] meas_heo_i,
    input  logic [EYE_W-1:0] meas_veo_i,
    input  logic             meas_no_hits_i,
    input  logic             meas_closed_i,
    output logic             lock_ok_o,
    output logic             eye_evt_o,
    output logic             clean_o
);
    logic      active;
    logic      acq_waiting;
    logic      timer_run;
    logic      timer_expire;
    logic      trig;
    logic      accept;
    logic      timeout;
    eye_meas_t meas;
    eye_thr_t  lock_thr;
    eye_thr_t  irq_thr;

    always_comb begin
        active    = mon_en_i && cdr_lock_i && adapt_done_i;
        timer_run = active && !acq_waiting;
        trig      = timer_expire || (man_ovr_en_i && man_req_i);
        meas      = '{heo: meas_heo_i, veo: meas_veo_i,
                      no_hits: meas_no_hits_i, closed: meas_closed_i};
        lock_thr  = '{heo: heo_lock_thr_i, veo: veo_lock_thr_i};
        irq_thr   = '{heo: heo_irq_thr_i, veo: veo_irq_thr_i};
    end

    interval_timer #(
        .TICKS_PER_BASE(TICKS_PER_BASE),
        .PER_W         (PER_W)
    ) i_timer (
        .clk     (clk),
        .rst     (rst),
        .run_i   (timer_run),
        .tick_i  (tick_i),
        .period_i(period_i),
        .expire_o(timer_expire)
    );

    acq_sequencer #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) i_seq (
        .clk      (clk),
        .rst      (rst),
        .active_i (active),
        .trig_i   (trig),
        .done_i   (meas_done_i),
        .start_o  (meas_start_o),
        .waiting_o(acq_waiting),
        .accept_o (accept),
        .timeout_o(timeout)
    );

    eye_qualifier i_qual (
        .clk       (clk),
        .rst       (rst),
        .cdr_lock_i(cdr_lock_i),
        .accept_i  (accept),
        .timeout_i (timeout),
        .meas_i    (meas),
        .lock_thr_i(lock_thr),
        .irq_thr_i (irq_thr),
        .lock_ok_o (lock_ok_o),
        .evt_o     (eye_evt_o),
        .clean_o   (clean_o)
    );

endmodule

// File: rtl/eye_lock_monitor_chk.sv
module eye_lock_monitor_chk (
    input logic clk,
    input logic rst,
    input logic mon_en_i,
    input logic cdr_lock_i,
    input logic adapt_done_i,
    input logic meas_start_o,
    input logic meas_done_i,
    input logic meas_closed_i,
    input logic acq_waiting,
    input logic lock_ok_o,
    input logic eye_evt_o
);
    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        meas_start_o |=> !meas_start_o);

    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        meas_start_o |-> $past(mon_en_i && cdr_lock_i && adapt_done_i));

    // R7
    evt_source_chk: assert property (@(posedge clk) disable iff (rst)
        eye_evt_o |-> $past(meas_done_i && acq_waiting));

    // R5
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_ok_o) |-> $past(meas_done_i && acq_waiting));

    // R6
    closed_nolock_chk: assert property (@(posedge clk) disable iff (rst)
        $past(meas_done_i && acq_waiting && meas_closed_i
              && mon_en_i && cdr_lock_i && adapt_done_i) |-> !lock_ok_o);

endmodule

bind eye_lock_monitor eye_lock_monitor_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .mon_en_i     (mon_en_i),
    .cdr_lock_i   (cdr_lock_i),
    .adapt_done_i (adapt_done_i),
    .meas_start_o (meas_start_o),
    .meas_done_i  (meas_done_i),
    .meas_closed_i(meas_closed_i),
    .acq_waiting  (acq_waiting),
    .lock_ok_o    (lock_ok_o),
    .eye_evt_o    (eye_evt_o)
);

// File: tb/test_eye_lock_monitor.sv
`timescale 1ns/1ps
module test_eye_lock_monitor;
    localparam int TPB = 13;
    localparam int TO  = 64;

    // heo6 veo6 closed1 nohits1 hlock4 vlock4 hirq4 virq4 explock1 expevt1
    localparam logic [31:0] VEC [9] = '{
        {6'd16, 6'd16, 1'b0, 1'b1, 4'd4,  4'd4,  4'd1, 4'd1, 1'b1, 1'b0},
        {6'd15, 6'd16, 1'b0, 1'b0, 4'd4,  4'd4,  4'd1, 4'd1, 1'b0, 1'b0},
        {6'd16, 6'd15, 1'b0, 1'b1, 4'd4,  4'd4,  4'd1, 4'd1, 1'b0, 1'b0},
        {6'd60, 6'd60, 1'b0, 1'b1, 4'd15, 4'd15, 4'd1, 4'd1, 1'b1, 1'b0},
        {6'd59, 6'd63, 1'b0, 1'b0, 4'd15, 4'd15, 4'd1, 4'd1, 1'b0, 1'b0},
        {6'd63, 6'd63, 1'b1, 1'b0, 4'd0,  4'd0,  4'd0, 4'd0, 1'b0, 1'b1},
        {6'd3,  6'd40, 1'b0, 1'b0, 4'd0,  4'd0,  4'd1, 4'd1, 1'b1, 1'b1},
        {6'd8,  6'd8,  1'b0, 1'b1, 4'd2,  4'd2,  4'd2, 4'd3, 1'b1, 1'b1},
        {6'd0,  6'd0,  1'b0, 1'b0, 4'd0,  4'd0,  4'd0, 4'd0, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic mon_en = 1'b0, cdr_lock = 1'b0, adapt_done = 1'b0;
    logic [3:0] period = 4'd1;
    logic [3:0] hl = 4'd4, vl = 4'd4, hi = 4'd1, vi = 4'd1;
    logic man_ovr = 1'b0, man_req = 1'b0;
    logic meas_start, meas_done = 1'b0;
    logic [5:0] m_heo = '0, m_veo = '0;
    logic m_nohits = 1'b0, m_closed = 1'b0;
    logic lock_ok, eye_evt, clean;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    eye_lock_monitor #(.TICKS_PER_BASE(TPB), .TIMEOUT_CYC(TO)) i_eye_lock_monitor (
        .clk(clk), .rst(rst), .tick_i(tick), .mon_en_i(mon_en),
        .cdr_lock_i(cdr_lock), .adapt_done_i(adapt_done), .period_i(period),
        .heo_lock_thr_i(hl), .veo_lock_thr_i(vl), .heo_irq_thr_i(hi),
        .veo_irq_thr_i(vi), .man_ovr_en_i(man_ovr), .man_req_i(man_req),
        .meas_start_o(meas_start), .meas_done_i(meas_done),
        .meas_heo_i(m_heo), .meas_veo_i(m_veo), .meas_no_hits_i(m_nohits),
        .meas_closed_i(m_closed), .lock_ok_o(lock_ok), .eye_evt_o(eye_evt),
        .clean_o(clean)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_start(input int limit, output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!meas_start && n < limit);
    endtask

    task automatic respond(input logic [5:0] h, input logic [5:0] v,
                           input logic cl, input logic nh);
        meas_done = 1'b1; m_heo = h; m_veo = v; m_closed = cl; m_nohits = nh;
        step();
        meas_done = 1'b0;
    endtask

    task automatic man_fire();
        man_req = 1'b1;
        step();
        man_req = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL R3 watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        #1;
        // R1 reset state
        repeat (3) step();
        check("R1 start in reset", meas_start, 0);
        check("R1 lock in reset", lock_ok, 0);
        rst = 1'b0;
        step();
        check("R1 evt after reset", eye_evt, 0);
        check("R1 clean after reset", clean, 0);

        // R2 gating: monitor disabled
        cdr_lock = 1'b1; adapt_done = 1'b1; mon_en = 1'b0;
        wait_start(60, n);
        check("R2 no start when disabled", meas_start, 0);
        // R8 manual ignored while inactive even with override
        man_ovr = 1'b1;
        man_fire();
        check("R8 manual while inactive", meas_start, 0);
        // R2 gating: adaptation not done
        mon_en = 1'b1; adapt_done = 1'b0;
        wait_start(60, n);
        check("R2 no start before adaptation", meas_start, 0);
        man_ovr = 1'b0;

        // R3 interval lengths
        adapt_done = 1'b1;
        wait_start(400, n);
        check("R3 period 1 interval", n, TPB);
        respond(6'd20, 6'd20, 1'b0, 1'b1);
        check("R5 lock after pass", lock_ok, 1);
        period = 4'd2;
        wait_start(400, n);
        check("R3 period 2 interval", n, 2 * TPB);
        respond(6'd20, 6'd20, 1'b0, 1'b1);
        period = 4'd0;
        wait_start(400, n);
        check("R3 period 0 treated as 1", n, TPB);
        respond(6'd20, 6'd20, 1'b0, 1'b1);
        period = 4'd10;
        wait_start(400, n);
        check("R3 period 10 interval", n, 10 * TPB);

        // R4 no further start while pending
        for (int k = 0; k < 10; k++) begin
            step();
            if (meas_start) check("R4 extra start while pending", 1, 0);
        end
        check("R4 pending no start", meas_start, 0);
        respond(6'd20, 6'd20, 1'b0, 1'b1);
        check("R5 lock held after pass", lock_ok, 1);

        // R9 timeout
        period = 4'd0;
        wait_start(400, n);
        check("R9 start before timeout", meas_start, 1);
        repeat (TO - 1) step();
        check("R9 lock held until timeout", lock_ok, 1);
        step();
        check("R9 lock cleared at timeout", lock_ok, 0);
        check("R9 no event on timeout", eye_evt, 0);

        // R11 stray done while idle
        respond(6'd30, 6'd30, 1'b0, 1'b1);
        check("R11 stray done lock", lock_ok, 0);
        check("R11 stray done evt", eye_evt, 0);
        check("R11 stray done clean", clean, 1);

        // R8 manual without override ignored, with override honored
        man_ovr = 1'b0;
        man_fire();
        check("R8 manual without override", meas_start, 0);
        man_ovr = 1'b1;
        man_fire();
        check("R8 manual with override", meas_start, 1);
        respond(6'd20, 6'd20, 1'b0, 1'b0);
        check("R5 lock after manual pass", lock_ok, 1);
        check("R12 clean cleared", clean, 0);

        // R10 raw lock loss
        cdr_lock = 1'b0;
        #1;
        check("R10 same-cycle drop", lock_ok, 0);
        step();
        cdr_lock = 1'b1;
        #1;
        check("R10 stays low after relock", lock_ok, 0);
        wait_start(400, n);
        check("R3 timer restarted after relock", n, TPB);
        respond(6'd20, 6'd20, 1'b0, 1'b1);
        check("R10 lock after new pass", lock_ok, 1);

        // vector table: R5, R6, R7, R12
        period = 4'd10;
        for (int i = 0; i < 9; i++) begin
            logic [31:0] v;
            v = VEC[i];
            hl = v[17:14]; vl = v[13:10]; hi = v[9:6]; vi = v[5:2];
            man_fire();
            check("R8 vector start", meas_start, 1);
            respond(v[31:26], v[25:20], v[19], v[18]);
            check(v[19] ? "R6 closed lock" : "R5 vector lock", lock_ok, v[1]);
            check("R7 vector event", eye_evt, v[0]);
            check("R12 vector clean", clean, v[18]);
            step();
            check("R7 event one cycle", eye_evt, 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule